// File: doc/BRIEF.md
# Pixel Clock Divider Controller

This block turns one pixel clock into the two slower clocks that the rest of a display pipeline needs. The first is a load clock whose rate follows the pixel multiplex mode. In two-to-one mode, two pixels arrive per load, so the load clock runs at half the pixel rate. In one-to-one mode it runs at the full pixel rate. The load clock is generated at the rate the pixel load input expects, so it can be looped straight back to that input. The second output is a programmable clock for an external graphics controller or frame-buffer shift logic. It divides the pixel clock by 4, 8, 16 or 32, and this ratio is chosen independently of the multiplex mode.

Both clocks are decoded from one free-running counter, so they remain phase-aligned after reset. Each clock comes with a single-cycle enable strobe. Downstream logic can use the strobe and stay in the pixel clock domain. A change of the divide ratio waits for a period boundary that the old and the new ratio share, so no shortened pulse appears on the programmable clock.

Top module: `pclk_div_ctrl`

## Requirements
- R1: With `mux_ratio` = 1 (two-to-one mode), `load_clk` is high in every cycle whose count since reset is even and low in every odd cycle. Cycle 0 is the first cycle after reset is released.
- R2: With `mux_ratio` = 1, `load_en` is high exactly in the odd cycles, which are the last cycle of each load period.
- R3: With `mux_ratio` = 0 (one-to-one mode), `load_clk` and `load_en` are both held at 1 in every cycle.
- R4: `div_sel` selects the divisor N as 0 = 4, 1 = 8, 2 = 16 and 3 = 32. In each period of N cycles, `prog_clk` is high for the first N/2 cycles and low for the last N/2.
- R5: `prog_en` is high in the last cycle of each programmable period and low in every other cycle.
- R6: Every programmable period begins on a cycle count that is a multiple of N. In two-to-one mode, `prog_en` is therefore never high unless `load_en` is also high.
- R7: A new `div_sel` value takes effect in the first cycle whose count is a multiple of both the old and the new N. No high or low phase of `prog_clk` is ever shorter than the smaller of the two half-periods.
- R8: `mux_ratio` has no effect on `prog_clk` or `prog_en`.
- R9: While `rst_n` is low, the counter is held at zero and the active divisor is N = 4. The value of `div_sel` present in cycle 0 is taken up at once, because cycle 0 is a period start for every ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| mux_ratio | input | 1 | 1 selects two-to-one mode, 0 selects one-to-one mode |
| div_sel | input | 2 | Programmable divisor select (4, 8, 16, 32) |
| load_clk | output | 1 | Load clock at pixel rate / M |
| load_en | output | 1 | Single-cycle strobe on the last cycle of each load period |
| prog_clk | output | 1 | Programmable clock at pixel rate / N, 50% duty |
| prog_en | output | 1 | Single-cycle strobe on the last cycle of each programmable period |

## Verification
The hardest corner case is a divisor change that arrives in the middle of a period, in both directions. A change from /4 to /32 made right after a /4 boundary must wait for the next multiple of 32. A design that switched at the next /4 boundary would start a /32 period on a count that is not a multiple of 32, and its first high phase would be too short. A change from /32 to /8 made mid-period must also wait for the /32 boundary. A design that switched at once would cut the low phase short. The bench also toggles the multiplex mode while the programmable clock is running, to show that a design which coupled N to M would be caught. Finally, it reasserts reset with a non-default select, to check that cycle 0 adopts the requested ratio immediately rather than first running one period at /4.

// File: rtl/pclk_div_pkg.sv
package pclk_div_pkg;

   // Multiplex relationship between pixel clock and load clock.
   typedef enum logic {
      MUX_ONE_TO_ONE = 1'b0,
      MUX_TWO_TO_ONE = 1'b1
   } mux_mode_e;

   // Width of the shared counter: enough bits for the largest divisor.
   function automatic int cnt_width(input int min_log, input int sel_w);
      return min_log + (1 << sel_w) - 1;
   endfunction

endpackage

// File: rtl/pclk_free_counter.sv
module pclk_free_counter #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] count
);

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("pclk_free_counter: CNT_W must be at least 1");
      end
   endgenerate

   // Free-running; all divisors are powers of two dividing 2**CNT_W,
   // so wrap-around is always a common period boundary.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= count + 1'b1;
   end

endmodule

// File: rtl/pclk_ratio_tracker.sv
module pclk_ratio_tracker #(
   parameter int MIN_LOG = 2,
   parameter int SEL_W   = 2,
   parameter int CNT_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic [SEL_W-1:0] req_sel,
   output logic [SEL_W-1:0] eff_sel
);

   localparam int NSEL = 1 << SEL_W;

   logic [SEL_W-1:0] held_sel;
   logic [SEL_W-1:0] wide_sel;
   logic [NSEL-1:0]  at_start;
   logic             common_start;

   // at_start[s] is set when the counter sits on a period start for ratio s.
   for (genvar s = 0; s < NSEL; s++) begin : g_start
      assign at_start[s] = ~|count[MIN_LOG+s-1:0];
   end

   // A boundary shared by both ratios is a boundary of the larger one.
   assign wide_sel     = (req_sel > held_sel) ? req_sel : held_sel;
   assign common_start = at_start[wide_sel];
   assign eff_sel      = common_start ? req_sel : held_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_sel <= '0;
      else        held_sel <= eff_sel;
   end

endmodule

// File: rtl/pclk_prog_gen.sv
module pclk_prog_gen #(
   parameter int MIN_LOG = 2,
   parameter int SEL_W   = 2,
   parameter int CNT_W   = 5
) (
   input  logic [CNT_W-1:0] count,
   input  logic [SEL_W-1:0] sel,
   output logic             div_clk,
   output logic             div_en
);

   localparam int NSEL = 1 << SEL_W;

   logic [NSEL-1:0] clk_opt;
   logic [NSEL-1:0] en_opt;

   // Ratio s divides by 2**(MIN_LOG+s): the top bit of that window gives
   // the half-period phase, and all ones marks the terminal cycle.
   for (genvar s = 0; s < NSEL; s++) begin : g_ratio
      assign clk_opt[s] = ~count[MIN_LOG+s-1];
      assign en_opt[s]  = &count[MIN_LOG+s-1:0];
   end

   assign div_clk = clk_opt[sel];
   assign div_en  = en_opt[sel];

endmodule

// File: rtl/pclk_load_gen.sv
module pclk_load_gen
   import pclk_div_pkg::*;
(
   input  logic      phase_bit,
   input  mux_mode_e mode,
   output logic      ld_clk,
   output logic      ld_en
);

   always_comb begin
      if (mode == MUX_TWO_TO_ONE) begin
         ld_clk = ~phase_bit;
         ld_en  = phase_bit;
      end else begin
         // Full-rate load: the pixel clock itself is the load clock, so
         // the enable stays active and the level output stays high.
         ld_clk = 1'b1;
         ld_en  = 1'b1;
      end
   end

endmodule

// File: rtl/pclk_div_ctrl.sv
module pclk_div_ctrl
   import pclk_div_pkg::*;
#(
   parameter int MIN_LOG = 2,
   parameter int SEL_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mux_ratio,
   input  logic [SEL_W-1:0] div_sel,
   output logic             load_clk,
   output logic             load_en,
   output logic             prog_clk,
   output logic             prog_en
);

   localparam int CNT_W = cnt_width(MIN_LOG, SEL_W);

   generate
      if (MIN_LOG < 1) begin : g_bad_min
         $error("pclk_div_ctrl: smallest divisor must be at least 2");
      end
      if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
         $error("pclk_div_ctrl: SEL_W must be between 1 and 3");
      end
   endgenerate

   logic [CNT_W-1:0] count;
   logic [SEL_W-1:0] eff_sel;
   mux_mode_e        mode;

   assign mode = mux_mode_e'(mux_ratio);

   pclk_free_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .count (count)
   );

   pclk_ratio_tracker #(.MIN_LOG(MIN_LOG), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .count   (count),
      .req_sel (div_sel),
      .eff_sel (eff_sel)
   );

   pclk_prog_gen #(.MIN_LOG(MIN_LOG), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_prog (
      .count   (count),
      .sel     (eff_sel),
      .div_clk (prog_clk),
      .div_en  (prog_en)
   );

   pclk_load_gen u_load (
      .phase_bit (count[0]),
      .mode      (mode),
      .ld_clk    (load_clk),
      .ld_en     (load_en)
   );

endmodule

// File: rtl/pclk_div_ctrl_chk.sv
module pclk_div_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic mux_ratio,
   input logic load_clk,
   input logic load_en,
   input logic prog_clk,
   input logic prog_en
);

   logic [6:0] hi_len;
   logic [6:0] lo_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_len <= '0;
         lo_len <= '0;
      end else begin
         hi_len <= prog_clk ? hi_len + 1'b1 : '0;
         lo_len <= prog_clk ? '0 : lo_len + 1'b1;
      end
   end

   a_r1_low_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (mux_ratio && load_en) |-> !load_clk);

   a_r2_strobe_alternates: assert property (@(posedge clk) disable iff (!rst_n)
      (mux_ratio && load_en ##1 mux_ratio) |-> !load_en);

   a_r3_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
      !mux_ratio |-> (load_en && load_clk));

   a_r5_new_period_high: assert property (@(posedge clk) disable iff (!rst_n)
      prog_en |=> prog_clk);

   a_r6_nested_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_en && mux_ratio) |-> load_en);

   a_r7_no_short_high: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prog_clk) |-> (hi_len >= 7'd2));

   a_r7_no_short_low: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(prog_clk) && lo_len != 7'd0) |-> (lo_len >= 7'd2));

endmodule

bind pclk_div_ctrl pclk_div_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mux_ratio (mux_ratio),
   .load_clk  (load_clk),
   .load_en   (load_en),
   .prog_clk  (prog_clk),
   .prog_en   (prog_en)
);

// File: tb/pclk_div_ctrl_test.sv
module pclk_div_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mux_ratio = 1'b1;
   logic [1:0] div_sel = 2'd0;
   logic       load_clk, load_en, prog_clk, prog_en;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // Reference model state
   int t = 0;        // cycles since reset release
   int act_n = 4;    // active programmable divisor

   always #10 clk = ~clk;   // 50 MHz

   pclk_div_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mux_ratio (mux_ratio),
      .div_sel   (div_sel),
      .load_clk  (load_clk),
      .load_en   (load_en),
      .prog_clk  (prog_clk),
      .prog_en   (prog_en)
   );

   task automatic check1(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s at t=%0d: actual=%0b expected=%0b", req, what, t, act, exp);
      end
   endtask

   // Compare on the falling edge, then advance the model to the next rising edge.
   always @(negedge clk) begin
      int new_n, eff_n, wide;
      logic e_lclk, e_len, e_pclk, e_pen;
      if (!rst_n) begin
         t = 0;        // R9: counter held at zero, divisor /4
         act_n = 4;
      end
      new_n = 4 << div_sel;
      wide  = (new_n > act_n) ? new_n : act_n;
      eff_n = ((t % wide) == 0) ? new_n : act_n;
      if (mux_ratio) begin
         e_lclk = ((t % 2) == 0);
         e_len  = ((t % 2) == 1);
      end else begin
         e_lclk = 1'b1;
         e_len  = 1'b1;
      end
      e_pclk = ((t % eff_n) < eff_n / 2);
      e_pen  = ((t % eff_n) == eff_n - 1);
      if (!done) begin
         check1(mux_ratio ? "R1" : "R3", "load_clk", load_clk, e_lclk);
         check1(mux_ratio ? "R2" : "R3", "load_en",  load_en,  e_len);
         check1("R4/R7", "prog_clk", prog_clk, e_pclk);
         check1("R5/R6", "prog_en",  prog_en,  e_pen);
      end
      if (rst_n) begin
         act_n = eff_n;
         t++;
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : stim
      // R9: reset state with default select
      step(3);
      rst_n = 1'b1;
      // R1 R2 R4 R5: /4 in two-to-one mode
      step(40);
      // R7: /4 -> /32 just after a /4 boundary; must wait for a multiple of 32
      div_sel = 2'd3;
      step(100);
      // R7: /32 -> /8 in the middle of a /32 period
      step(5);
      div_sel = 2'd1;
      step(80);
      // R7: /8 -> /16 mid-period
      step(3);
      div_sel = 2'd2;
      step(70);
      // R3 R8: one-to-one mode while the programmable clock keeps running
      mux_ratio = 1'b0;
      step(50);
      div_sel = 2'd0;
      step(37);
      mux_ratio = 1'b1;
      step(41);
      // R7: a request that reverts before the shared boundary
      div_sel = 2'd3;
      step(6);
      div_sel = 2'd0;
      step(60);
      // R9: reset in mid-run with /16 requested; cycle 0 adopts it at once
      div_sel = 2'd2;
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
      step(70);
      // R6: nested strobes at /32 with mode toggling
      div_sel = 2'd3;
      step(50);
      mux_ratio = 1'b0;
      step(21);
      mux_ratio = 1'b1;
      step(90);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule